// File: doc/BRIEF.md
# Port I/O Instruction Executor

This block runs one port transfer for an 8-bit processor core that has a 16-bit address bus. When `start` is pulsed while the block is idle, it decodes the opcode and the byte that follows it. The following byte is either an immediate port number or the second byte of a prefixed instruction. The block then latches a snapshot of the register file, A, B, C, D, E, H, L and F. It drives the port address, and for writes it also drives the data. It fires a single read or write strobe. When the instruction finishes, it presents a write-back and flag update for the core to apply.

Two instruction families are handled. The immediate family reads a port into A or writes A to a port. Its port number is the immediate byte, and A supplies the upper address byte. The register-indirect family follows the prefix byte. C supplies the lower address byte and B the upper. A 3-bit field selects the source or destination register, and code 110 has a special meaning. For input it updates only the flags. For output it sends F. Only register-indirect input changes the flags.

The controller has six states. IDLE waits for `start` and moves to ADDR for a recognised instruction or to BAD otherwise. ADDR always moves to STROBE. STROBE moves to HOLD, or straight to DONE when the instruction is only three cycles long. HOLD stays until the cycle count reaches its final value, then moves to DONE. DONE and BAD both return to IDLE.

Top module: `pio_exec`

## Requirements
- R1: Opcode 0xDB with immediate n reads the port at address {A, n}, where A is in bits 15..8 and n in bits 7..0. The byte read is written back to register code 111 (A), and `flag_we` stays low.
- R2: Opcode 0xD3 with immediate n writes A to the port at address {A, n}. There is no register write-back and no flag write.
- R3: Prefix 0xED followed by second byte 01rrr000 reads the port at address {B, C} and writes the byte to register r. The register codes are B=000, C=001, D=010, E=011, H=100, L=101 and A=111, and `wb_sel` carries r.
- R4: Prefix 0xED followed by second byte 01rrr001 writes register r to the port at address {B, C}. When r=110, the byte written is F.
- R5: A register-indirect input with r=110 produces no register write-back (`wb_en` low), but its flag update still happens.
- R6: Register-indirect input sets `flag_we` and `flag_out` as follows. Bit 7 (S) is input bit 7. Bit 6 (Z) is 1 when the input is zero. Bit 4 (H) is 0. Bit 2 (P/V) is 1 when the input has an even number of ones. Bit 1 (N) is 0. Bits 5, 3 and 0 are copied from F.
- R7: Call the cycle after `start` is sampled cycle 0. Exactly one strobe occurs, lasting one cycle, in cycle 1. It is `io_rd` for input forms and `io_wr` for output forms. The address, and the data for writes, are already driven in cycle 0 and do not change during the strobe.
- R8: `done` is a one-cycle pulse in cycle IMM_CYCLES-1 for the immediate forms and in cycle IND_CYCLES-1 for the register-indirect forms. The write-back and flag outputs are valid only in that cycle.
- R9: An opcode that is not recognised, including a 0xED prefix with any other second byte, pulses `illegal` in cycle 0. It causes no strobe and no `done`.
- R10: While reset is asserted, every output is zero.
- R11: A `start` that arrives while an instruction is in progress is ignored. The result uses the opcode and registers latched at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (accepted in IDLE only) |
| opcode | input | 8 | First instruction byte |
| operand | input | 8 | Immediate port number or second byte after the prefix |
| reg_a | input | 8 | Register A |
| reg_b | input | 8 | Register B |
| reg_c | input | 8 | Register C |
| reg_d | input | 8 | Register D |
| reg_e | input | 8 | Register E |
| reg_h | input | 8 | Register H |
| reg_l | input | 8 | Register L |
| reg_f | input | 8 | Flag register F |
| io_rdata | input | 8 | Byte returned by the port, sampled at the read strobe |
| io_addr | output | 16 | Port address |
| io_wdata | output | 8 | Byte driven to the port for writes |
| io_rd | output | 1 | One-cycle read strobe |
| io_wr | output | 1 | One-cycle write strobe |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for an unrecognised opcode |
| wb_en | output | 1 | Register write-back enable (in the done cycle) |
| wb_sel | output | 3 | Destination register code |
| wb_data | output | 8 | Byte to write back |
| flag_we | output | 1 | Flag register update enable (in the done cycle) |
| flag_out | output | 8 | New flag register value |

## Verification
The bench uses the default lengths: 11 cycles for the immediate forms and 12 for the register-indirect forms. Because the two lengths differ, a form that takes the wrong cycle-count path is caught by the exact `done` cycle. The bench checks every register code in both directions, including the 110 cases. It drives data bytes that set the zero, sign and parity flags, mixed with random bytes. It also sends unknown opcodes and prefixed codes outside the two valid patterns, and pulses `start` again during a transfer.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_STROBE, ST_HOLD, ST_DONE, ST_BAD
    } pio_state_e;

    typedef enum logic [2:0] {
        FM_NONE, FM_IMM_IN, FM_IMM_OUT, FM_IND_IN, FM_IND_OUT
    } pio_form_e;

    localparam logic [7:0] OPC_IMM_IN  = 8'hDB;
    localparam logic [7:0] OPC_IMM_OUT = 8'hD3;
    localparam logic [7:0] OPC_PREFIX  = 8'hED;

    localparam logic [2:0] RF_FLAGS = 3'b110;
    localparam logic [2:0] RF_ACC   = 3'b111;

    function automatic logic even_ones(input logic [7:0] v);
        return ~^v;
    endfunction

endpackage

// File: rtl/pio_decode.sv
module pio_decode
    import pio_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [7:0] operand,
    output pio_form_e  form,
    output logic [2:0] rfield
);

    always_comb begin
        form = FM_NONE;
        case (opcode)
            OPC_IMM_IN:  form = FM_IMM_IN;
            OPC_IMM_OUT: form = FM_IMM_OUT;
            OPC_PREFIX: begin
                if (operand[7:6] == 2'b01 && operand[2:1] == 2'b00)
                    form = operand[0] ? FM_IND_OUT : FM_IND_IN;
            end
            default: form = FM_NONE;
        endcase
        rfield = (form == FM_IMM_IN || form == FM_IMM_OUT) ? RF_ACC : operand[5:3];
    end

endmodule

// File: rtl/pio_regsel.sv
module pio_regsel (
    input  logic [2:0] sel,
    input  logic [7:0] ra,
    input  logic [7:0] rb,
    input  logic [7:0] rc,
    input  logic [7:0] rd,
    input  logic [7:0] re,
    input  logic [7:0] rh,
    input  logic [7:0] rl,
    input  logic [7:0] rf,
    output logic [7:0] val
);

    always_comb begin
        unique case (sel)
            3'b000:  val = rb;
            3'b001:  val = rc;
            3'b010:  val = rd;
            3'b011:  val = re;
            3'b100:  val = rh;
            3'b101:  val = rl;
            3'b110:  val = rf;
            default: val = ra;
        endcase
    end

endmodule

// File: rtl/pio_flags.sv
module pio_flags
    import pio_pkg::*;
(
    input  logic [7:0] din,
    input  logic [2:0] keep,   // {F[5], F[3], F[0]}
    output logic [7:0] fout
);

    always_comb begin
        fout = {din[7], (din == 8'h00), keep[2], 1'b0,
                keep[1], even_ones(din), 1'b0, keep[0]};
    end

endmodule

// File: rtl/pio_exec.sv
module pio_exec
    import pio_pkg::*;
#(
    parameter int IMM_CYCLES = 11,
    parameter int IND_CYCLES = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  opcode,
    input  logic [7:0]  operand,
    input  logic [7:0]  reg_a,
    input  logic [7:0]  reg_b,
    input  logic [7:0]  reg_c,
    input  logic [7:0]  reg_d,
    input  logic [7:0]  reg_e,
    input  logic [7:0]  reg_h,
    input  logic [7:0]  reg_l,
    input  logic [7:0]  reg_f,
    input  logic [7:0]  io_rdata,
    output logic [15:0] io_addr,
    output logic [7:0]  io_wdata,
    output logic        io_rd,
    output logic        io_wr,
    output logic        done,
    output logic        illegal,
    output logic        wb_en,
    output logic [2:0]  wb_sel,
    output logic [7:0]  wb_data,
    output logic        flag_we,
    output logic [7:0]  flag_out
);

    localparam int MAX_CYC = (IMM_CYCLES > IND_CYCLES) ? IMM_CYCLES : IND_CYCLES;
    localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] IMM_LAST = CNT_W'(IMM_CYCLES - 2);
    localparam logic [CNT_W-1:0] IND_LAST = CNT_W'(IND_CYCLES - 2);

    pio_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    pio_form_e         form_dec, form_q;
    logic [2:0]        rfield_dec, rfield_q;
    logic [7:0]        op_q, rdata_q;
    logic [7:0]        a_q, b_q, c_q, d_q, e_q, h_q, l_q, f_q;
    logic [7:0]        sel_val, flag_calc;
    logic              is_in, is_imm, at_last;

    pio_decode u_decode (
        .opcode  (opcode),
        .operand (operand),
        .form    (form_dec),
        .rfield  (rfield_dec)
    );

    pio_regsel u_regsel (
        .sel (rfield_q),
        .ra  (a_q), .rb (b_q), .rc (c_q), .rd (d_q),
        .re  (e_q), .rh (h_q), .rl (l_q), .rf (f_q),
        .val (sel_val)
    );

    pio_flags u_flags (
        .din  (rdata_q),
        .keep ({f_q[5], f_q[3], f_q[0]}),
        .fout (flag_calc)
    );

    assign is_in   = (form_q == FM_IMM_IN) || (form_q == FM_IND_IN);
    assign is_imm  = (form_q == FM_IMM_IN) || (form_q == FM_IMM_OUT);
    assign at_last = (cnt_q == (is_imm ? IMM_LAST : IND_LAST));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = (form_dec == FM_NONE) ? ST_BAD : ST_ADDR;
            ST_ADDR:   state_d = ST_STROBE;
            ST_STROBE: state_d = at_last ? ST_DONE : ST_HOLD;
            ST_HOLD:   state_d = at_last ? ST_DONE : ST_HOLD;
            ST_DONE:   state_d = ST_IDLE;
            ST_BAD:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == ST_IDLE) ? '0 : cnt_q + 1'b1;
        end
    end

    // operand snapshot and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            form_q <= FM_NONE; rfield_q <= '0; op_q <= '0; rdata_q <= '0;
            a_q <= '0; b_q <= '0; c_q <= '0; d_q <= '0;
            e_q <= '0; h_q <= '0; l_q <= '0; f_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                form_q <= form_dec; rfield_q <= rfield_dec; op_q <= operand;
                a_q <= reg_a; b_q <= reg_b; c_q <= reg_c; d_q <= reg_d;
                e_q <= reg_e; h_q <= reg_h; l_q <= reg_l; f_q <= reg_f;
            end
            if (state_q == ST_STROBE && is_in)
                rdata_q <= io_rdata;
        end
    end

    // outputs
    always_comb begin
        io_addr  = '0; io_wdata = '0; io_rd = 1'b0; io_wr = 1'b0;
        done     = 1'b0; illegal = 1'b0;
        wb_en    = 1'b0; wb_sel = '0; wb_data = '0;
        flag_we  = 1'b0; flag_out = '0;
        unique case (state_q)
            ST_ADDR, ST_STROBE, ST_HOLD: begin
                io_addr  = is_imm ? {a_q, op_q} : {b_q, c_q};
                io_wdata = is_in ? 8'h00 : sel_val;
                if (state_q == ST_STROBE) begin
                    io_rd = is_in;
                    io_wr = !is_in;
                end
            end
            ST_DONE: begin
                done = 1'b1;
                if (is_in && !(form_q == FM_IND_IN && rfield_q == RF_FLAGS)) begin
                    wb_en   = 1'b1;
                    wb_sel  = rfield_q;
                    wb_data = rdata_q;
                end
                if (form_q == FM_IND_IN) begin
                    flag_we  = 1'b1;
                    flag_out = flag_calc;
                end
            end
            ST_BAD:  illegal = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/pio_exec_chk.sv
module pio_exec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        io_rd,
    input logic        io_wr,
    input logic [15:0] io_addr,
    input logic [7:0]  io_wdata,
    input logic        done,
    input logic        illegal,
    input logic        wb_en,
    input logic        flag_we
);

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_wr));

    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) |=> !(io_rd || io_wr));

    assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) |-> ($stable(io_addr) && $stable(io_wdata)));

    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!io_rd && !io_wr && !done && !wb_en && !flag_we));

    assert_wb_in_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en || flag_we) |-> done);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_strobe_not_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) |-> !done);

endmodule

bind pio_exec pio_exec_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .done     (done),
    .illegal  (illegal),
    .wb_en    (wb_en),
    .flag_we  (flag_we)
);

// File: tb/pio_exec_bench.sv
module pio_exec_bench;

    localparam int CLK_PERIOD = 10;
    localparam int IMM_N = 11;
    localparam int IND_N = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0, operand = '0, io_rdata = '0;
    logic [7:0]  regs_tb [8];   // index = register code; 6 = F, 7 = A
    logic [15:0] io_addr;
    logic [7:0]  io_wdata, wb_data, flag_out;
    logic        io_rd, io_wr, done, illegal, wb_en, flag_we;
    logic [2:0]  wb_sel;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_exec #(.IMM_CYCLES(IMM_N), .IND_CYCLES(IND_N)) u_pio_exec (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .operand(operand),
        .reg_a(regs_tb[7]), .reg_b(regs_tb[0]), .reg_c(regs_tb[1]), .reg_d(regs_tb[2]),
        .reg_e(regs_tb[3]), .reg_h(regs_tb[4]), .reg_l(regs_tb[5]), .reg_f(regs_tb[6]),
        .io_rdata(io_rdata), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rd(io_rd), .io_wr(io_wr), .done(done), .illegal(illegal),
        .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data),
        .flag_we(flag_we), .flag_out(flag_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (op %h %h)", tag, act, exp, opcode, operand);
        end
    endtask

    function automatic logic [7:0] exp_flags(input logic [7:0] din, input logic [7:0] fin);
        return {din[7], din == 8'h00, fin[5], 1'b0, fin[3], ~^din, 1'b0, fin[0]};
    endfunction

    task automatic run_instr(input logic [7:0] opc, input logic [7:0] opd,
                             input logic [7:0] pdata, input bit poke);
        bit is_imm, is_ind, is_in, legal;
        logic [7:0]  e_reg [8];
        logic [2:0]  rf;
        int n_strobe, strobe_cyc, done_cyc, ill_cyc, n_len;
        bit saw_rd, saw_wr, s_wb_en, s_fwe;
        logic [15:0] s_addr;
        logic [7:0]  s_wdata, s_wb_data, s_fout;
        logic [2:0]  s_wb_sel;
        string atag;

        is_imm = (opc == 8'hDB) || (opc == 8'hD3);
        is_ind = (opc == 8'hED) && (opd[7:6] == 2'b01) && (opd[2:1] == 2'b00);
        legal  = is_imm || is_ind;
        is_in  = (opc == 8'hDB) || (is_ind && !opd[0]);
        rf     = is_imm ? 3'b111 : opd[5:3];
        n_len  = is_imm ? IMM_N : IND_N;
        for (int k = 0; k < 8; k++) e_reg[k] = regs_tb[k];

        @(negedge clk);
        opcode = opc; operand = opd; io_rdata = pdata; start = 1'b1;
        @(posedge clk);
        n_strobe = 0; strobe_cyc = -1; done_cyc = -1; ill_cyc = -1;
        saw_rd = 0; saw_wr = 0; s_wb_en = 0; s_fwe = 0;
        s_addr = '0; s_wdata = '0; s_wb_data = '0; s_fout = '0; s_wb_sel = '0;
        for (int cyc = 0; cyc < 20; cyc++) begin
            @(negedge clk);
            if (cyc == 0) start = 1'b0;
            if (poke && cyc == 2) begin
                start = 1'b1; opcode = 8'hD3; operand = ~opd;
                for (int k = 0; k < 8; k++) regs_tb[k] = ~e_reg[k];
            end
            if (poke && cyc == 4) start = 1'b0;
            if (io_rd || io_wr) begin
                n_strobe++; strobe_cyc = cyc; saw_rd = io_rd; saw_wr = io_wr;
                s_addr = io_addr; s_wdata = io_wdata;
            end
            if (done && done_cyc < 0) begin
                done_cyc = cyc; s_wb_en = wb_en; s_wb_sel = wb_sel;
                s_wb_data = wb_data; s_fwe = flag_we; s_fout = flag_out;
            end
            if (illegal && ill_cyc < 0) ill_cyc = cyc;
            if (done_cyc >= 0 || ill_cyc >= 0) break;
        end
        if (poke) for (int k = 0; k < 8; k++) regs_tb[k] = e_reg[k];

        if (!legal) begin
            chk(ill_cyc == 0, "R9 illegal pulse", ill_cyc, 0);
            chk(n_strobe == 0 && done_cyc < 0, "R9 no bus activity", n_strobe, 0);
            return;
        end
        chk(ill_cyc < 0, "R9 no illegal for valid opcode", ill_cyc, -1);
        chk(n_strobe == 1 && strobe_cyc == 1, "R7 strobe cycle", strobe_cyc, 1);
        chk(saw_rd == is_in && saw_wr == !is_in, "R7 strobe kind", {saw_rd, saw_wr}, {is_in, !is_in});
        atag = is_imm ? (is_in ? "R1 address" : "R2 address") : (is_in ? "R3 address" : "R4 address");
        chk(s_addr == (is_imm ? {e_reg[7], opd} : {e_reg[0], e_reg[1]}), atag, s_addr,
            is_imm ? {e_reg[7], opd} : {e_reg[0], e_reg[1]});
        if (!is_in)
            chk(s_wdata == e_reg[rf], is_imm ? "R2 write data" : "R4 write data", s_wdata, e_reg[rf]);
        chk(done_cyc == n_len - 1, "R8 done cycle", done_cyc, n_len - 1);
        if (is_in && !(is_ind && rf == 3'b110)) begin
            chk(s_wb_en && s_wb_sel == rf && s_wb_data == pdata,
                is_imm ? "R1 write-back" : "R3 write-back", {s_wb_en, s_wb_sel, s_wb_data}, {1'b1, rf, pdata});
        end else begin
            chk(!s_wb_en, is_in ? "R5 no write-back" : "R2 no write-back", s_wb_en, 0);
        end
        if (is_ind && is_in)
            chk(s_fwe && s_fout == exp_flags(pdata, e_reg[6]), "R6 flags", {s_fwe, s_fout},
                {1'b1, exp_flags(pdata, e_reg[6])});
        else
            chk(!s_fwe, "R1 flags untouched", s_fwe, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] opc, opd;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 8; k++) regs_tb[k] = 8'h11 * (k + 1);
        repeat (3) @(negedge clk);
        chk({io_rd, io_wr, done, illegal, wb_en, flag_we} == 6'b0 && io_addr == 16'h0
            && io_wdata == 8'h0 && flag_out == 8'h0, "R10 reset outputs",
            {io_rd, io_wr, done, illegal, wb_en, flag_we}, 0);
        rst_n = 1'b1;

        // directed
        regs_tb[7] = 8'h12; regs_tb[0] = 8'hB0; regs_tb[1] = 8'hC1; regs_tb[6] = 8'h29;
        run_instr(8'hDB, 8'h34, 8'h5A, 0);   // R1
        run_instr(8'hD3, 8'hFE, 8'h00, 0);   // R2
        run_instr(8'hED, 8'h78, 8'h81, 0);   // R3 into A
        run_instr(8'hED, 8'h40, 8'h03, 0);   // R3 into B
        run_instr(8'hED, 8'h70, 8'h00, 0);   // R5 zero, even parity
        run_instr(8'hED, 8'h70, 8'h80, 0);   // R6 sign set, odd parity
        regs_tb[6] = 8'hD6;
        run_instr(8'hED, 8'h70, 8'h7F, 0);   // R6 kept bits
        run_instr(8'hED, 8'h71, 8'h00, 0);   // R4 sends F
        run_instr(8'hED, 8'h41, 8'h00, 0);   // R4 sends B
        run_instr(8'h00, 8'h00, 8'h00, 0);   // R9
        run_instr(8'hED, 8'hA2, 8'h00, 0);   // R9 other prefixed code
        run_instr(8'hED, 8'h58, 8'h3C, 1);   // R11 start during transfer
        run_instr(8'hDB, 8'h07, 8'hE1, 1);   // R11

        // constrained random
        for (int it = 0; it < 150; it++) begin
            for (int k = 0; k < 8; k++) regs_tb[k] = 8'($urandom);
            case ($urandom % 5)
                0: begin opc = 8'hDB; opd = 8'($urandom); end
                1: begin opc = 8'hD3; opd = 8'($urandom); end
                2: begin opc = 8'hED; opd = {2'b01, 3'($urandom), 3'b000}; end
                3: begin opc = 8'hED; opd = {2'b01, 3'($urandom), 3'b001}; end
                default: begin opc = 8'($urandom); opd = 8'($urandom); end
            endcase
            run_instr(opc, opd, 8'($urandom), ($urandom % 8) == 0);
        end

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule